// File: doc/BRIEF.md
# Ultra DMA Burst CRC Checker

This block keeps the 16-bit CRC that protects the data words of an Ultra DMA burst. The CRC is computed once per word, all sixteen bits at a time, because the bus gives no per-bit clock. A burst start loads the register with a fixed seed and arms the checker. Each new data word that arrives while the DMA acknowledge is asserted (`dmackN` low) is folded into the running value. Words that arrive after a pause and resume are counted in the same way.

When the acknowledge goes back high, the block latches the CRC word the host presents on the data bus. It compares that word with its own result and sets a sticky error flag if the two differ. The flag stays set until the controller starts a new command. The controller reads the flag when it posts the command's completion status.

The strobe-timing state machine and the analog timing of the bus live elsewhere. This block only sees a word-valid level that goes high once for each new word.

Top module: `udma_burst_crc`

## Requirements
- R1: After reset, `crcOut` is 16'h4ABA, `hostCrc` is 0, and both `crcErr` and `checkDone` are 0.
- R2: A clock with `burstStart` high loads `crcOut` with 16'h4ABA on that edge and arms the checker. Any word or acknowledge change in that same cycle is ignored.
- R3: A word is accepted on the clock where `wordValid` is high after having been low on the previous clock, provided the checker is armed and `dmackN` is low. The word is folded MSB-first with polynomial x^16+x^12+x^5+1 (16'h1021, no reflection, no final inversion). The new value appears on `crcOut` after that edge.
- R4: `wordValid` held high over several clocks updates the CRC only once.
- R5: Words are ignored when the checker is not armed, and also when `dmackN` is high.
- R6: Idle clocks with `dmackN` low (a pause) leave the CRC unchanged. Words accepted after the pause continue the same running value.
- R7: A clock where `dmackN` is high after being low on the previous clock, while the checker is armed, latches `wordData` into `hostCrc`. It also raises `checkDone` for exactly one cycle and disarms the checker.
- R8: If the latched word differs from the local CRC, `crcErr` becomes 1 and stays 1, including through later bursts whose CRC matches.
- R9: `cmdStart` clears `crcErr`. If a miscompare happens in the same cycle as `cmdStart`, the error is set.
- R10: A rise of `dmackN` while the checker is not armed latches nothing and raises no `checkDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdStart | input | 1 | New command; clears the sticky error |
| burstStart | input | 1 | Seeds the CRC and arms the checker |
| wordValid | input | 1 | High once per new data word |
| wordData | input | 16 | Data word, or the host CRC at burst end |
| dmackN | input | 1 | DMA acknowledge, active low |
| crcOut | output | 16 | Running local CRC |
| hostCrc | output | 16 | Last CRC word latched from the host |
| crcErr | output | 1 | Sticky CRC miscompare flag |
| checkDone | output | 1 | One-cycle pulse after each compare |

## Verification
The bench holds `wordValid` high across several clocks. A design that used the level instead of the edge would fold the word three times and finish with a wrong CRC. A pause between two words checks that the register holds its value, and a burst start issued together with a word checks that the seed wins. Acknowledge rises are driven with the checker armed and with it idle, so a capture that is not gated by the armed state shows up as a spurious `checkDone`. A correct burst after a failed one checks that the error flag is truly sticky, and a miscompare issued together with `cmdStart` checks the set-over-clear priority.

// File: rtl/udma_crc_pkg.sv
package udma_crc_pkg;
  typedef struct packed {
    logic seed;
    logic update;
    logic capture;
  } crcStrb_t;
endpackage

// File: rtl/udma_crc_dp.sv
module udma_crc_dp
  import udma_crc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] SEED = 16'h4ABA
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcStrb_t          strb,
  input  logic [DATA_W-1:0] wordData,
  output logic [CRC_W-1:0]  crcReg,
  output logic [CRC_W-1:0]  hostCrc,
  output logic              mismatch
);
  localparam int TOP = CRC_W - 1;

  // One XOR stage per data bit, MSB of the word first.
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    logic [CRC_W-1:0] prevC;
    logic [CRC_W-1:0] nxt;
    logic             fb;
    if (g == 0) begin : g_first
      assign prevC = crcReg;
    end else begin : g_rest
      assign prevC = g_bit[g-1].nxt;
    end
    assign fb  = prevC[TOP] ^ wordData[DATA_W-1-g];
    assign nxt = {prevC[TOP-1:0], 1'b0} ^ (fb ? POLY : '0);
  end

  logic [CRC_W-1:0] crcStep;
  assign crcStep  = g_bit[DATA_W-1].nxt;
  assign mismatch = (wordData[CRC_W-1:0] != crcReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg  <= SEED;
      hostCrc <= '0;
    end else begin
      if (strb.seed)        crcReg <= SEED;
      else if (strb.update) crcReg <= crcStep;
      if (strb.capture)     hostCrc <= wordData[CRC_W-1:0];
    end
  end

  p_seed_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.seed |=> crcReg == SEED);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.seed && !strb.update) |=> $stable(crcReg));
  p_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> hostCrc == $past(wordData[CRC_W-1:0]));
endmodule

// File: rtl/udma_crc_ctrl.sv
module udma_crc_ctrl
  import udma_crc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdStart,
  input  logic     burstStart,
  input  logic     wordValid,
  input  logic     dmackN,
  input  logic     mismatch,
  output crcStrb_t strb,
  output logic     crcErr,
  output logic     checkDone
);
  logic wvQ, dkQ, armed;

  always_comb begin
    strb.seed    = burstStart;
    strb.update  = wordValid & ~wvQ & ~dmackN & armed & ~burstStart;
    strb.capture = dmackN & ~dkQ & armed & ~burstStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wvQ       <= 1'b0;
      dkQ       <= 1'b1;
      armed     <= 1'b0;
      crcErr    <= 1'b0;
      checkDone <= 1'b0;
    end else begin
      wvQ       <= wordValid;
      dkQ       <= dmackN;
      checkDone <= strb.capture;
      crcErr    <= (crcErr & ~cmdStart) | (strb.capture & mismatch);
      if (burstStart)        armed <= 1'b1;
      else if (strb.capture) armed <= 1'b0;
    end
  end

  p_one_update_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.update |=> !strb.update);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    checkDone |=> !checkDone);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (crcErr && !cmdStart) |=> crcErr);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStart && !(strb.capture && mismatch)) |=> !crcErr);
  p_idle_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && !burstStart) |=> !checkDone);
endmodule

// File: rtl/udma_burst_crc.sv
module udma_burst_crc
  import udma_crc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] SEED = 16'h4ABA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              burstStart,
  input  logic              wordValid,
  input  logic [DATA_W-1:0] wordData,
  input  logic              dmackN,
  output logic [CRC_W-1:0]  crcOut,
  output logic [CRC_W-1:0]  hostCrc,
  output logic              crcErr,
  output logic              checkDone
);
  crcStrb_t strb;
  logic     mismatch;

  udma_crc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .burstStart(burstStart),
    .wordValid(wordValid), .dmackN(dmackN), .mismatch(mismatch),
    .strb(strb), .crcErr(crcErr), .checkDone(checkDone)
  );

  udma_crc_dp #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY), .SEED(SEED)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wordData(wordData),
    .crcReg(crcOut), .hostCrc(hostCrc), .mismatch(mismatch)
  );
endmodule

// File: tb/udma_burst_crc_tb.sv
module udma_burst_crc_tb;
  localparam logic [15:0] SEED = 16'h4ABA;

  logic clk = 1'b0, rstN = 1'b0, cmdStart = 1'b0, burstStart = 1'b0;
  logic wordValid = 1'b0, dmackN = 1'b1;
  logic [15:0] wordData = '0;
  logic [15:0] crcOut, hostCrc;
  logic crcErr, checkDone;

  int errs = 0, checks = 0;
  bit finished = 0;

  udma_burst_crc u_dut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .burstStart(burstStart),
    .wordValid(wordValid), .wordData(wordData), .dmackN(dmackN),
    .crcOut(crcOut), .hostCrc(hostCrc), .crcErr(crcErr), .checkDone(checkDone)
  );

  always #2 clk = ~clk;

  // Polynomial long division of (crc ^ word) * x^16 by 0x11021.
  function automatic logic [15:0] refStep(logic [15:0] c, logic [15:0] d);
    logic [31:0] r;
    r = {c ^ d, 16'h0000};
    for (int i = 31; i >= 16; i--)
      if (r[i]) r = r ^ (32'h11021 << (i - 16));
    return r[15:0];
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference, advanced every clock and compared 1 ns later.
  logic [15:0] mCrc = SEED, mHost = '0;
  logic mErr = 0, mDone = 0, mArmed = 0, mWvQ = 0, mDkQ = 1;
  always @(posedge clk) begin
    if (!rstN) begin
      mCrc = SEED; mHost = '0; mErr = 0; mDone = 0; mArmed = 0; mWvQ = 0; mDkQ = 1;
    end else begin
      bit acc, rel, mis;
      acc = wordValid && !mWvQ && !dmackN && mArmed && !burstStart;
      rel = dmackN && !mDkQ && mArmed && !burstStart;
      mis = (wordData != mCrc);
      mErr  = (mErr && !cmdStart) || (rel && mis);
      mDone = rel;
      if (rel) begin mHost = wordData; mArmed = 0; end
      if (burstStart) begin mCrc = SEED; mArmed = 1; end
      else if (acc) mCrc = refStep(mCrc, wordData);
      mWvQ = wordValid; mDkQ = dmackN;
    end
    #1;
    if (!finished) begin
      chk("R3 model crcOut", crcOut, mCrc);
      chk("R7 model hostCrc", hostCrc, mHost);
      chk("R8 model crcErr", {15'd0, crcErr}, {15'd0, mErr});
      chk("R7 model checkDone", {15'd0, checkDone}, {15'd0, mDone});
    end
  end

  task automatic pulseWord(logic [15:0] d);
    @(negedge clk); wordValid = 1; wordData = d;
    @(negedge clk); wordValid = 0;
  endtask

  task automatic startBurst();
    @(negedge clk); burstStart = 1; dmackN = 0;
    @(negedge clk); burstStart = 0;
  endtask

  task automatic endBurst(logic [15:0] d);
    @(negedge clk); wordData = d; dmackN = 1;
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] e;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 crcOut", crcOut, SEED);
    chk("R1 hostCrc", hostCrc, 16'h0);
    chk("R1 flags", {14'd0, crcErr, checkDone}, 16'h0);

    // R5: not armed, dmack low
    dmackN = 0;
    pulseWord(16'h1234);
    chk("R5 unarmed word ignored", crcOut, SEED);
    // R10: release while idle
    endBurst(16'hBEEF);
    chk("R10 no pulse", {15'd0, checkDone}, 16'h0);
    chk("R10 no capture", hostCrc, 16'h0);

    // R2: seed wins over a word in the same cycle
    @(negedge clk); burstStart = 1; dmackN = 0; wordValid = 1; wordData = 16'hFFFF;
    @(negedge clk); burstStart = 0; wordValid = 0;
    chk("R2 seed", crcOut, SEED);

    // R3: several words
    e = SEED;
    pulseWord(16'h0000); e = refStep(e, 16'h0000);
    pulseWord(16'hA5A5); e = refStep(e, 16'hA5A5);
    pulseWord(16'h8001); e = refStep(e, 16'h8001);
    pulseWord(16'hFFFF); e = refStep(e, 16'hFFFF);
    chk("R3 four words", crcOut, e);

    // R4: held strobe counts once
    @(negedge clk); wordValid = 1; wordData = 16'h3C3C;
    repeat (3) @(negedge clk);
    wordValid = 0; e = refStep(e, 16'h3C3C);
    chk("R4 held strobe once", crcOut, e);

    // R6: pause then resume
    repeat (5) @(negedge clk);
    chk("R6 pause holds", crcOut, e);
    pulseWord(16'h0F0F); e = refStep(e, 16'h0F0F);
    pulseWord(16'h7777); e = refStep(e, 16'h7777);
    chk("R6 resume continues", crcOut, e);

    // R7: matching release
    endBurst(e);
    chk("R7 checkDone", {15'd0, checkDone}, 16'h1);
    chk("R7 hostCrc", hostCrc, e);
    chk("R8 match no error", {15'd0, crcErr}, 16'h0);
    @(negedge clk);
    chk("R7 single pulse", {15'd0, checkDone}, 16'h0);

    // R5: armed but dmack high
    @(negedge clk); burstStart = 1;
    @(negedge clk); burstStart = 0;
    pulseWord(16'h5555);
    chk("R5 dmack high ignored", crcOut, SEED);

    // R8: mismatch then sticky
    @(negedge clk); dmackN = 0;
    pulseWord(16'h1111); e = refStep(SEED, 16'h1111);
    endBurst(e ^ 16'h0001);
    chk("R8 mismatch sets", {15'd0, crcErr}, 16'h1);
    startBurst();
    pulseWord(16'h2222); e = refStep(SEED, 16'h2222);
    endBurst(e);
    chk("R8 sticky after good burst", {15'd0, crcErr}, 16'h1);

    // R9: clear, then set wins over clear
    @(negedge clk); cmdStart = 1;
    @(negedge clk); cmdStart = 0;
    chk("R9 cleared", {15'd0, crcErr}, 16'h0);
    startBurst();
    pulseWord(16'h4444); e = refStep(SEED, 16'h4444);
    @(negedge clk); wordData = ~e; dmackN = 1; cmdStart = 1;
    @(negedge clk); cmdStart = 0;
    chk("R9 set beats clear", {15'd0, crcErr}, 16'h1);
    @(negedge clk); cmdStart = 1;
    @(negedge clk); cmdStart = 0;
    chk("R9 cleared again", {15'd0, crcErr}, 16'h0);

    @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule